// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits beside the command path of an SDRAM controller and supplies the column address for each beat of a read or write burst. When a column command is accepted, it takes the starting column, a 3-bit burst-length code and a burst-type bit. From the next cycle on it drives one column per clock, together with a valid flag and a flag that marks the final beat.

Bursts of 1, 2, 4 or 8 beats can step through their aligned column group in either of two orders. Sequential order wraps inside the group. Interleaved order XORs the beat index into the start column. A full-page burst walks the whole 512-column row and keeps going until something stops it. A new column command restarts the sequence at its own column. A precharge command ends the burst. A setting that the mode rules reserve is refused, and a one-cycle error pulse is raised.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While `rst_n` is low, `col_valid`, `col_last` and `cfg_err` are all 0.
- R2: A legal `start` sampled at a clock edge makes `col_valid` high from that edge on, with `col` equal to `start_col` on the first beat. The block then advances one beat per cycle, for 1, 2, 4 or 8 beats under length codes 000, 001, 010 and 011.
- R3: With `burst_ilv`=0 and burst length BL below full page, beat k shows `col` whose low log2(BL) bits are (start+k) mod BL. The bits above them equal those of `start_col`.
- R4: With `burst_ilv`=1 and burst length BL, beat k shows `col` whose low log2(BL) bits are start XOR k. The bits above them are unchanged.
- R5: `col_last` is high on exactly the final beat of a non-full-page burst. In the following cycle `col_valid` is low unless a new legal `start` was sampled.
- R6: Length code 111 with `burst_ilv`=0 is a full-page burst. Beat k shows (start_col+k) mod 512, the burst runs without limit and `col_last` never rises.
- R7: A legal `start` during a running burst abandons it. The next cycle shows beat 0 of the new burst at the new `start_col`.
- R8: `stop` (precharge) without a legal `start` makes `col_valid` low from the next cycle. When both arrive in the same cycle, the legal `start` wins.
- R9: Length codes 100, 101 and 110, and code 111 with `burst_ilv`=1, are reserved. A `start` carrying one is ignored: a running burst continues unchanged, an idle block stays idle, and `cfg_err` is high for the single following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Column (read or write) command accepted this cycle |
| start_col | input | 9 | Starting column of the command |
| len_code | input | 3 | Burst-length code |
| burst_ilv | input | 1 | Burst order: 0 sequential, 1 interleaved |
| stop | input | 1 | Precharge command ends the burst |
| col | output | 9 | Column of the current beat |
| col_valid | output | 1 | A burst beat is being presented |
| col_last | output | 1 | Current beat is the final one |
| cfg_err | output | 1 | One-cycle pulse after a refused reserved setting |

## Verification
The hardest situations to reach are the ones where a burst is still running when a second command arrives. These are a reserved setting that must leave the running burst untouched, a restart before the final beat, and a full page that has to wrap past column 511 before it is stopped. The stimulus issues these commands at chosen beat indices. One full-page burst is held for more than 512 beats, a reserved code is injected in the middle of an 8-beat burst, and start and stop are raised in the same cycle.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int unsigned LEN_CODE_W   = 3;
  localparam int unsigned LEN_MAX_POW  = 3;
  localparam logic [LEN_CODE_W-1:0] LEN_CODE_PAGE = 3'b111;

  typedef struct packed {
    logic legal;
    logic page;
  } len_class_t;

  function automatic len_class_t classify_len(input logic [LEN_CODE_W-1:0] code,
                                              input logic ilv);
    len_class_t r;
    r.page  = (code == LEN_CODE_PAGE);
    r.legal = (code <= LEN_CODE_W'(LEN_MAX_POW)) || (r.page && !ilv);
    return r;
  endfunction
endpackage

// File: rtl/colgen_decode.sv
module colgen_decode
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  ilv,
  output logic                  legal,
  output logic                  page,
  output logic [COL_W-1:0]      mask
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  len_class_t cls;
  logic [COL_W-1:0] pow_mask;

  always_comb begin
    cls      = classify_len(len_code, ilv);
    pow_mask = (ONE << len_code[1:0]) - ONE;
    legal    = cls.legal;
    page     = cls.page;
    mask     = cls.page ? '1 : pow_mask;
  end
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr #(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;

  always_comb sum = base + beat;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    always_comb begin
      if (mask[i]) col[i] = ilv ? (base[i] ^ beat[i]) : sum[i];
      else         col[i] = base[i];
    end
  end
endmodule

// File: rtl/colgen_sequencer.sv
module colgen_sequencer #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             legal,
  input  logic             page,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic             act,
  output logic             last,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] mask_q,
  output logic             ilv_q,
  output logic             err
);
  logic             act_q, act_d;
  logic             page_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q, beat_d;
  logic             err_q, err_d;
  logic             load_en;
  logic             beat_en;
  logic             last_c;

  always_comb begin
    last_c  = act_q && !page_q && (beat_q == mask_q);
    load_en = start && legal;
    err_d   = start && !legal;
    act_d   = act_q;
    beat_d  = beat_q;
    beat_en = 1'b0;
    if (load_en) begin
      act_d   = 1'b1;
      beat_d  = '0;
      beat_en = 1'b1;
    end else if (stop) begin
      act_d   = 1'b0;
    end else if (act_q) begin
      if (last_c) begin
        act_d = 1'b0;
      end else begin
        beat_d  = beat_q + COL_W'(1);
        beat_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      act_q <= act_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      page_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (load_en) begin
      base_q <= start_col;
      mask_q <= mask;
      page_q <= page;
      ilv_q  <= ilv;
    end
  end

  assign act  = act_q;
  assign last = last_c;
  assign base = base_q;
  assign beat = beat_q;
  assign err  = err_q;

  // R5
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_c && !start) |=> !act_q);

  // R8
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !act_q);

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !legal) |=> err_q);

  // R9
  reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !legal && !act_q) |=> !act_q);

  // R2
  beat_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !last_c && !start && !stop) |=> (act_q && beat_q != $past(beat_q)));
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             burst_ilv,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             col_valid,
  output logic             col_last,
  output logic             cfg_err
);
  logic             dec_legal;
  logic             dec_page;
  logic [COL_W-1:0] dec_mask;
  logic             seq_act;
  logic             seq_last;
  logic [COL_W-1:0] seq_base;
  logic [COL_W-1:0] seq_beat;
  logic [COL_W-1:0] seq_mask;
  logic             seq_ilv;
  logic             seq_err;

  colgen_decode #(.COL_W(COL_W)) u_decode (
    .len_code (len_code),
    .ilv      (burst_ilv),
    .legal    (dec_legal),
    .page     (dec_page),
    .mask     (dec_mask)
  );

  colgen_sequencer #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .legal     (dec_legal),
    .page      (dec_page),
    .mask      (dec_mask),
    .ilv       (burst_ilv),
    .start_col (start_col),
    .stop      (stop),
    .act       (seq_act),
    .last      (seq_last),
    .base      (seq_base),
    .beat      (seq_beat),
    .mask_q    (seq_mask),
    .ilv_q     (seq_ilv),
    .err       (seq_err)
  );

  colgen_addr #(.COL_W(COL_W)) u_addr (
    .base (seq_base),
    .beat (seq_beat),
    .mask (seq_mask),
    .ilv  (seq_ilv),
    .col  (col)
  );

  assign col_valid = seq_act;
  assign col_last  = seq_last;
  assign cfg_err   = seq_err;

  // R7
  restart_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dec_legal) |=> (col_valid && col == $past(start_col)));

  // R3
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !start && !stop) |=>
      ((col & ~seq_mask) == ($past(col) & ~seq_mask)));
endmodule

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [8:0] start_col;
  logic [2:0] len_code;
  logic       burst_ilv;
  logic       stop;
  logic [8:0] col;
  logic       col_valid;
  logic       col_last;
  logic       cfg_err;

  sdram_burst_colgen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .burst_ilv(burst_ilv), .stop(stop),
    .col(col), .col_valid(col_valid), .col_last(col_last), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int         due;
    int         req;
    logic       v;
    logic [8:0] c;
    logic       l;
    logic       e;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  logic       m_act = 0;
  logic [8:0] m_base = 0;
  int         m_k = 0;
  logic [2:0] m_code = 0;
  logic       m_ilv = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [8:0] model_col(logic [8:0] b, int k, logic [2:0] code, logic t);
    int n, lo;
    if (code == 3'b111) return 9'((int'(b) + k) % 512);
    n  = 1 << code;
    lo = t ? ((int'(b) % n) ^ k) : (((int'(b) % n) + k) % n);
    return 9'((int'(b) & ~(n - 1)) | lo);
  endfunction

  function automatic logic model_last();
    return m_act && m_code != 3'b111 && m_k == (1 << m_code) - 1;
  endfunction

  task automatic step(input logic s, input logic [8:0] c, input logic [2:0] lc,
                      input logic t, input logic p, input int req);
    logic legal;
    exp_t it;
    start = s; start_col = c; len_code = lc; burst_ilv = t; stop = p;
    legal = (lc <= 3'd3) || (lc == 3'b111 && !t);
    if (s && legal) begin
      m_act = 1; m_base = c; m_k = 0; m_code = lc; m_ilv = t;
    end else if (p) begin
      m_act = 0;
    end else if (m_act) begin
      if (model_last()) m_act = 0;
      else m_k = (m_k + 1) % 512;
    end
    it.due = cyc + 1; it.req = req;
    it.v = m_act;
    it.c = m_act ? model_col(m_base, m_k, m_code, m_ilv) : 9'd0;
    it.l = model_last();
    it.e = s && !legal;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n, input int req);
    for (int i = 0; i < n; i++) step(0, 9'd0, 3'd0, 0, 0, req);
  endtask

  task automatic run(input int n, input int req);
    idle(n, req);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t it;
      it = q.pop_front();
      n_chk++;
      if (col_valid !== it.v || col_last !== it.l || cfg_err !== it.e ||
          (it.v && col !== it.c)) begin
        n_fail++;
        $display("FAIL R%0d cyc %0d: valid=%b col=%h last=%b err=%b expected valid=%b col=%h last=%b err=%b",
                 it.req, cyc, col_valid, col, col_last, cfg_err, it.v, it.c, it.l, it.e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; start_col = 0; len_code = 0; burst_ilv = 0; stop = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    n_chk++;
    if (col_valid !== 0 || col_last !== 0 || cfg_err !== 0) begin
      n_fail++;
      $display("FAIL R1: valid=%b last=%b err=%b expected 0 0 0", col_valid, col_last, cfg_err);
    end
    @(posedge clk); #1;
    rst_n = 1;
    idle(2, 1);

    // R2 R5: single beat
    step(1, 9'h005, 3'd0, 0, 0, 2); idle(2, 5);
    // R3: length 2 sequential with wrap
    step(1, 9'h0FF, 3'd1, 0, 0, 3); idle(3, 3);
    // R3: length 4 sequential
    step(1, 9'h1A6, 3'd2, 0, 0, 3); idle(5, 3);
    // R4: length 8 interleaved
    step(1, 9'h0B5, 3'd3, 1, 0, 4); idle(9, 4);
    // R4: length 4 interleaved
    step(1, 9'h013, 3'd2, 1, 0, 4); idle(5, 4);
    // R2: length 8 sequential
    step(1, 9'h10A, 3'd3, 0, 0, 2); idle(9, 2);
    // R6: full page, beyond 512 beats, then stopped (R8)
    step(1, 9'h1FC, 3'd7, 0, 0, 6); run(520, 6);
    step(0, 9'd0, 3'd0, 0, 1, 8); idle(2, 8);
    // R7: restart mid-burst
    step(1, 9'h040, 3'd3, 0, 0, 7); run(2, 7);
    step(1, 9'h101, 3'd1, 1, 0, 7); idle(3, 7);
    // R7: restart on the final beat
    step(1, 9'h022, 3'd1, 0, 0, 7); run(1, 7);
    step(1, 9'h077, 3'd2, 0, 0, 7); idle(5, 7);
    // R8: stop mid-burst
    step(1, 9'h0C0, 3'd3, 0, 0, 8); run(2, 8);
    step(0, 9'd0, 3'd0, 0, 1, 8); idle(2, 8);
    // R8: start and stop together, start wins
    step(1, 9'h033, 3'd2, 0, 1, 8); idle(5, 8);
    // R9: reserved codes while idle
    step(1, 9'h011, 3'd4, 0, 0, 9); idle(2, 9);
    step(1, 9'h011, 3'd5, 1, 0, 9); idle(1, 9);
    step(1, 9'h011, 3'd6, 0, 0, 9); idle(1, 9);
    step(1, 9'h011, 3'd7, 1, 0, 9); idle(2, 9);
    // R9: reserved code in the middle of a running burst
    step(1, 9'h150, 3'd3, 0, 0, 9); run(2, 9);
    step(1, 9'h0AA, 3'd7, 1, 0, 9); idle(8, 9);

    idle(2, 1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule